// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a two-wire serial bus slave that gives an external host read and write access to a file of byte-wide configuration registers. An oversampling system clock samples the bus. Both lines pass through a two-flop synchronizer and then a glitch filter. The slave finds start, repeated-start and stop conditions on the filtered lines, and it pulls the data line low through an open-drain enable. It does not stretch the clock.

The host picks the access type with the top bit of the command byte that follows the address. With the top bit set, the host accesses one register, and the low seven bits give its offset. With the top bit clear, the host makes a block access from offset 0 upward. A block write first sends a byte count. A block read first returns a fixed count byte. A window of registers is staged: writes that land inside it are held in shadow storage and take effect only when a write outside the window arrives. A separate read port lets downstream logic observe the register contents.

Top module: `cfgx_serial_slave`

## Requirements
- R1: After reset every register holds the parameter `RST_VAL` and the slave does not pull the data line low.
- R2: The strap input selects the 7-bit address: when it is 0 the address is `ADDR_A` (write byte D2h), and when it is 1 the address is `ADDR_B` (write byte DAh). The slave acknowledges only the selected address.
- R3: After an address that does not match, the slave leaves the data line released for the acknowledge slot and for every later byte, and it changes no register until the next start condition.
- R4: A command byte with bit 7 = 1 starts a single-register write at offset bits 6:0. Exactly one data byte is acknowledged and stored. A second data byte is not acknowledged and leaves the next register unchanged.
- R5: After a command byte with bit 7 = 1, a repeated start and the address with read bit 1, the slave returns the register at the given offset.
- R6: A command byte with bit 7 = 0 starts a block write at offset 0 whatever bits 6:0 hold. The next byte is a count N. Up to N data bytes are acknowledged and stored at ascending offsets, and the offset wraps modulo the register count. A byte beyond N is not acknowledged. A stop after any complete byte keeps the bytes already stored.
- R7: After a block command, a repeated start and a read address, the slave returns the parameter `BLK_RD_CNT` and then the registers from offset 0 upward, one per byte, for as long as the master acknowledges.
- R8: A write to an offset from `STG_LO` to `STG_HI` does not change the visible register. The next write to any offset outside that window stores its own byte and also makes every staged byte visible in the same clock.
- R9: A start condition at any point, including inside a byte, abandons the transfer in progress, and the slave decodes the bytes that follow as a new address.
- R10: A level change on either bus line that lasts fewer than `FILT_LEN` system clocks is ignored.
- R11: The slave changes its data-line drive only while the filtered clock line is low.
- R12: The downstream read port returns the register at `dn_addr_i` one clock after that address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_low_o | output | 1 | When 1, the pad pulls the data line low |
| addr_sel_i | input | 1 | Address strap: 0 selects ADDR_A, 1 selects ADDR_B |
| dn_addr_i | input | REG_AW | Downstream read address |
| dn_data_o | output | 8 | Downstream read data, one clock after the address |

## Verification
The bench builds the block with `FILT_LEN` = 3, `BLK_RD_CNT` = 4, `RST_VAL` = 3Ch and the staging window at 32 to 63. A 3-clock filter means that a 2-clock clock-line spike falls just below the threshold, so the filter boundary is tested exactly. A short block-read count keeps the count byte, the data bytes and the final not-acknowledge within a few bytes of bus time. A reset value other than zero makes untouched, staged and aborted registers clearly different from written ones.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_CNT,
    ST_WR,
    ST_RD
  } slv_st_e;

  typedef enum logic [1:0] {
    AK_NONE,
    AK_ARM,
    AK_SLOT
  } ack_ph_e;

  typedef struct packed {
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
    logic sda;
  } bus_ev_t;

endpackage

// File: rtl/cfgx_line_filter.sv
module cfgx_line_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic filt
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync <= 2'b11;
      filt <= 1'b1;
      cnt  <= '0;
    end else begin
      sync <= {sync[0], raw};
      if (sync[1] != filt) begin
        if (cnt == CW'(FILT_LEN - 1)) begin
          filt <= sync[1];
          cnt  <= '0;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end else begin
        cnt <= '0;
      end
    end
  end

  // R10: the filtered level moves only after the synchronized level disagreed
  p_filt_follow_r10: assert property (@(posedge clk) disable iff (rst)
    !$stable(filt) |-> $past(sync[1] != filt));

endmodule

// File: rtl/cfgx_bus_front.sv
module cfgx_bus_front import cfgx_pkg::*; #(
  parameter int FILT_LEN = 4
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    scl_raw,
  input  logic    sda_raw,
  output bus_ev_t ev,
  output logic    scl_lvl
);
  localparam int NLINE = 2;

  logic [NLINE-1:0] raw_v;
  logic [NLINE-1:0] filt_v;
  logic [NLINE-1:0] prev_v;

  assign raw_v = {sda_raw, scl_raw};

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    cfgx_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk  (clk),
      .rst  (rst),
      .raw  (raw_v[g]),
      .filt (filt_v[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) prev_v <= '1;
    else     prev_v <= filt_v;
  end

  assign scl_lvl     = filt_v[0];
  assign ev.sda      = filt_v[1];
  assign ev.scl_rise = filt_v[0] & ~prev_v[0];
  assign ev.scl_fall = ~filt_v[0] & prev_v[0];
  assign ev.start    = filt_v[0] & prev_v[0] & prev_v[1] & ~filt_v[1];
  assign ev.stop     = filt_v[0] & prev_v[0] & ~prev_v[1] & filt_v[1];

endmodule

// File: rtl/cfgx_regfile.sv
module cfgx_regfile #(
  parameter int          AW      = 8,
  parameter int          DW      = 8,
  parameter logic [7:0]  RST_VAL = 8'h00,
  parameter int          STG_LO  = 32,
  parameter int          STG_HI  = 63
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic [AW-1:0] dn_addr,
  output logic [DW-1:0] dn_data
);
  localparam int DEPTH = 1 << AW;
  localparam int STG_N = STG_HI - STG_LO + 1;
  localparam int SW    = (STG_N > 1) ? $clog2(STG_N) : 1;

  logic [DW-1:0]    mem  [DEPTH];
  logic [DW-1:0]    stg  [STG_N];
  logic [STG_N-1:0] pend;
  logic             in_rng;
  logic [SW-1:0]    stg_idx;

  assign in_rng  = (int'(wr_addr) >= STG_LO) && (int'(wr_addr) <= STG_HI);
  assign stg_idx = SW'(wr_addr - AW'(STG_LO));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= DW'(RST_VAL);
      pend <= '0;
    end else if (wr_en) begin
      if (in_rng) begin
        stg[stg_idx]  <= wr_data;
        pend[stg_idx] <= 1'b1;
      end else begin
        mem[wr_addr] <= wr_data;
        for (int i = 0; i < STG_N; i++) begin
          if (pend[i]) mem[AW'(STG_LO + i)] <= stg[i];
        end
        pend <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    rd_data <= mem[rd_addr];
    dn_data <= mem[dn_addr];
  end

  // R8: an outside write leaves nothing pending
  p_stage_commit_r8: assert property (@(posedge clk) disable iff (rst)
    wr_en && !in_rng |=> pend == '0);
  // R8: a write inside the window is held pending
  p_stage_hold_r8: assert property (@(posedge clk) disable iff (rst)
    wr_en && in_rng |=> pend != '0);

endmodule

// File: rtl/cfgx_proto.sv
module cfgx_proto import cfgx_pkg::*; #(
  parameter logic [6:0] ADDR_A     = 7'h69,
  parameter logic [6:0] ADDR_B     = 7'h6D,
  parameter int         BLK_RD_CNT = 8,
  parameter int         AW         = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  bus_ev_t       ev,
  input  logic          scl_lvl,
  input  logic          addr_sel,
  output logic          sda_low,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data
);
  localparam logic [7:0] CNT_BYTE = 8'(BLK_RD_CNT);

  slv_st_e       st, nxt;
  ack_ph_e       ackph;
  logic [2:0]    bit_cnt;
  logic [7:0]    shreg, txreg, wr_left;
  logic [AW-1:0] ptr;
  logic          blk, send_cnt, ack_ok, rd_more;
  logic [6:0]    my_addr;
  logic [7:0]    rx_byte;

  assign my_addr = addr_sel ? ADDR_B : ADDR_A;
  assign rx_byte = {shreg[6:0], ev.sda};
  assign rd_addr = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;  nxt <= ST_IDLE;  ackph <= AK_NONE;
      bit_cnt <= '0;  shreg <= '0;  txreg <= '0;  wr_left <= '0;
      ptr <= '0;  blk <= 1'b0;  send_cnt <= 1'b0;  ack_ok <= 1'b0;
      rd_more <= 1'b0;  sda_low <= 1'b0;
      wr_en <= 1'b0;  wr_addr <= '0;  wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (ev.start) begin
        st <= ST_ADDR;  ackph <= AK_NONE;  bit_cnt <= '0;  sda_low <= 1'b0;
      end else if (ev.stop) begin
        st <= ST_IDLE;  ackph <= AK_NONE;  bit_cnt <= '0;  sda_low <= 1'b0;
      end else if (st != ST_IDLE) begin
        if (ev.scl_rise) begin
          if (ackph == AK_NONE) begin
            bit_cnt <= bit_cnt + 3'd1;
            if (st != ST_RD) shreg <= rx_byte;
            if (bit_cnt == 3'd7) begin
              ackph <= AK_ARM;
              unique case (st)
                ST_ADDR: begin
                  if (rx_byte[7:1] != my_addr) begin
                    ack_ok <= 1'b0;  nxt <= ST_IDLE;
                  end else if (rx_byte[0]) begin
                    ack_ok <= 1'b1;  nxt <= ST_RD;  send_cnt <= blk;
                  end else begin
                    ack_ok <= 1'b1;  nxt <= ST_CMD;
                  end
                end
                ST_CMD: begin
                  ack_ok  <= 1'b1;
                  blk     <= ~rx_byte[7];
                  ptr     <= rx_byte[7] ? AW'(rx_byte[6:0]) : '0;
                  nxt     <= rx_byte[7] ? ST_WR : ST_CNT;
                  wr_left <= rx_byte[7] ? 8'd1 : 8'd0;
                end
                ST_CNT: begin
                  ack_ok <= 1'b1;  wr_left <= rx_byte;  nxt <= ST_WR;
                end
                ST_WR: begin
                  if (wr_left != 8'd0) begin
                    ack_ok  <= 1'b1;
                    wr_en   <= 1'b1;
                    wr_addr <= ptr;
                    wr_data <= rx_byte;
                    ptr     <= ptr + AW'(1);
                    wr_left <= wr_left - 8'd1;
                    nxt     <= ST_WR;
                  end else begin
                    ack_ok <= 1'b0;  nxt <= ST_IDLE;
                  end
                end
                default: begin
                  ack_ok <= 1'b0;  nxt <= ST_IDLE;
                end
              endcase
            end
          end else if (ackph == AK_SLOT && st == ST_RD) begin
            rd_more <= ~ev.sda;
          end
        end else if (ev.scl_fall) begin
          if (ackph == AK_NONE) begin
            if (st == ST_RD) sda_low <= ~txreg[~bit_cnt];
          end else if (ackph == AK_ARM) begin
            sda_low <= (st != ST_RD) && ack_ok;
            ackph   <= AK_SLOT;
          end else begin
            ackph   <= AK_NONE;
            bit_cnt <= '0;
            sda_low <= 1'b0;
            if (st == ST_RD) begin
              if (rd_more) begin
                txreg   <= rd_data;
                sda_low <= ~rd_data[7];
                ptr     <= ptr + AW'(1);
              end else begin
                st <= ST_IDLE;
              end
            end else begin
              st <= nxt;
              if (nxt == ST_RD) begin
                if (send_cnt) begin
                  txreg    <= CNT_BYTE;
                  sda_low  <= ~CNT_BYTE[7];
                  send_cnt <= 1'b0;
                end else begin
                  txreg   <= rd_data;
                  sda_low <= ~rd_data[7];
                  ptr     <= ptr + AW'(1);
                end
              end
            end
          end
        end
      end
    end
  end

  // R3: an idle slave never holds the data line
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    st == ST_IDLE |-> !sda_low);
  // R11: the drive asserts only while the clock line is low
  p_drive_scl_low_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_low) |-> !scl_lvl);
  // R9: a start returns the engine to address decode with the line free
  p_start_resync_r9: assert property (@(posedge clk) disable iff (rst)
    ev.start |=> (st == ST_ADDR) && (ackph == AK_NONE) && !sda_low);
  // R4: the acknowledge slot starts only on a byte boundary
  p_slot_align_r4: assert property (@(posedge clk) disable iff (rst)
    ackph != AK_NONE |-> bit_cnt == 3'd0);

endmodule

// File: rtl/cfgx_serial_slave.sv
module cfgx_serial_slave import cfgx_pkg::*; #(
  parameter int         FILT_LEN   = 4,
  parameter logic [6:0] ADDR_A     = 7'h69,
  parameter logic [6:0] ADDR_B     = 7'h6D,
  parameter int         BLK_RD_CNT = 8,
  parameter logic [7:0] RST_VAL    = 8'h00,
  parameter int         STG_LO     = 32,
  parameter int         STG_HI     = 63,
  parameter int         REG_AW     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_low_o,
  input  logic              addr_sel_i,
  input  logic [REG_AW-1:0] dn_addr_i,
  output logic [7:0]        dn_data_o
);
  bus_ev_t           ev;
  logic              scl_lvl;
  logic              wr_en;
  logic [REG_AW-1:0] wr_addr, rd_addr;
  logic [7:0]        wr_data, rd_data;

  cfgx_bus_front #(.FILT_LEN(FILT_LEN)) u_front (
    .clk     (clk),
    .rst     (rst),
    .scl_raw (scl_i),
    .sda_raw (sda_i),
    .ev      (ev),
    .scl_lvl (scl_lvl)
  );

  cfgx_proto #(
    .ADDR_A     (ADDR_A),
    .ADDR_B     (ADDR_B),
    .BLK_RD_CNT (BLK_RD_CNT),
    .AW         (REG_AW)
  ) u_proto (
    .clk      (clk),
    .rst      (rst),
    .ev       (ev),
    .scl_lvl  (scl_lvl),
    .addr_sel (addr_sel_i),
    .sda_low  (sda_low_o),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data)
  );

  cfgx_regfile #(
    .AW      (REG_AW),
    .DW      (8),
    .RST_VAL (RST_VAL),
    .STG_LO  (STG_LO),
    .STG_HI  (STG_HI)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .dn_addr (dn_addr_i),
    .dn_data (dn_data_o)
  );

endmodule

// File: tb/cfgx_serial_slave_tb_top.sv
module cfgx_serial_slave_tb_top;
  localparam int         Q     = 20;
  localparam logic [7:0] RV    = 8'h3C;
  localparam logic [7:0] DEV_A = 8'hD2;
  localparam logic [7:0] DEV_B = 8'hDA;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       strap = 1'b0;
  logic       glitch_en = 1'b0;
  logic [7:0] dn_addr = '0;
  logic [7:0] dn_data;
  logic       sda_low;
  logic       sda_bus;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [7:0] exp_v[$];
  string      exp_t[$];
  logic [7:0] obs_val;
  event       obs_ev;

  assign sda_bus = m_sda & ~sda_low;

  always #2ns clk = ~clk;

  cfgx_serial_slave #(
    .FILT_LEN   (3),
    .BLK_RD_CNT (4),
    .RST_VAL    (RV),
    .STG_LO     (32),
    .STG_HI     (63)
  ) dut_i (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl),
    .sda_i      (sda_bus),
    .sda_low_o  (sda_low),
    .addr_sel_i (strap),
    .dn_addr_i  (dn_addr),
    .dn_data_o  (dn_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pops one expectation per observed byte
  initial begin
    forever begin
      @(obs_ev);
      if (exp_v.size() == 0) chk("scoreboard-empty", 32'd1, 32'd0);
      else chk(exp_t.pop_front(), {24'd0, obs_val}, {24'd0, exp_v.pop_front()});
    end
  end

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_rstart();
    m_sda = 1'b1; wq(); scl = 1'b1; wq(); m_sda = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(); scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  task automatic put_bit(input logic b);
    m_sda = b; wq();
    if (glitch_en) begin
      scl = 1'b1; repeat (2) @(negedge clk); scl = 1'b0; wq();
    end
    scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    m_sda = 1'b1; wq(); scl = 1'b1; wq(); ack = sda_bus; wq(); scl = 1'b0; wq();
  endtask

  // exp: expected bus level in the acknowledge slot (0 acknowledged, 1 not)
  task automatic sendk(input string tag, input logic [7:0] b, input logic exp);
    logic a;
    send_byte(b, a);
    chk(tag, {31'd0, a}, {31'd0, exp});
  endtask

  task automatic recv_expect(input string tag, input logic [7:0] exp, input bit m_ack);
    logic [7:0] v;
    exp_v.push_back(exp);
    exp_t.push_back(tag);
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1'b1; wq(); scl = 1'b1; wq(); v[i] = sda_bus; wq(); scl = 1'b0; wq();
    end
    m_sda = m_ack ? 1'b0 : 1'b1; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    m_sda = 1'b1;
    obs_val = v;
    ->obs_ev;
  endtask

  task automatic wr_reg(input string tag, input logic [7:0] dev, input logic [6:0] off,
                        input logic [7:0] val);
    bus_start();
    sendk(tag, dev, 1'b0);
    sendk(tag, {1'b1, off}, 1'b0);
    sendk(tag, val, 1'b0);
    bus_stop();
  endtask

  task automatic rd_reg(input string tag, input logic [6:0] off, input logic [7:0] exp);
    bus_start();
    sendk(tag, DEV_A, 1'b0);
    sendk(tag, {1'b1, off}, 1'b0);
    bus_rstart();
    sendk(tag, DEV_A | 8'h01, 1'b0);
    recv_expect(tag, exp, 1'b0);
    bus_stop();
  endtask

  task automatic dn_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk); dn_addr = a;
    @(negedge clk);
    chk(tag, {24'd0, dn_data}, {24'd0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk("R1 sda released", {31'd0, sda_low}, 32'd0);
    dn_chk("R1 reg0 default", 8'd0, RV);
    dn_chk("R1 reg40 default", 8'd40, RV);
    dn_chk("R1 reg255 default", 8'd255, RV);
    rd_reg("R1/R5 read default reg9", 7'd9, RV);

    // R12 one-clock downstream latency
    @(negedge clk); dn_addr = 8'd1;
    @(negedge clk); dn_addr = 8'd2;
    chk("R12 latency", {24'd0, dn_data}, {24'd0, RV});

    // R4 single write, second data byte refused; R2 address A acked
    bus_start();
    sendk("R2 addr A ack", DEV_A, 1'b0);
    sendk("R4 cmd ack", 8'h86, 1'b0);
    sendk("R4 data ack", 8'h42, 1'b0);
    sendk("R4 extra byte nack", 8'h43, 1'b1);
    bus_stop();
    dn_chk("R4 reg6 stored", 8'd6, 8'h42);
    dn_chk("R4 reg7 untouched", 8'd7, RV);

    // R5 byte read
    rd_reg("R5 read reg6", 7'd6, 8'h42);

    // R8 staging window
    wr_reg("R8 wr40", DEV_A, 7'd40, 8'h77);
    dn_chk("R8 reg40 hidden", 8'd40, RV);
    rd_reg("R8 read40 hidden", 7'd40, RV);
    wr_reg("R8 wr41", DEV_A, 7'd41, 8'h88);
    dn_chk("R8 reg41 hidden", 8'd41, RV);
    wr_reg("R8 wr2 commit", DEV_A, 7'd2, 8'h11);
    dn_chk("R8 reg40 visible", 8'd40, 8'h77);
    dn_chk("R8 reg41 visible", 8'd41, 8'h88);
    dn_chk("R8 reg2 stored", 8'd2, 8'h11);

    // R6 block write with count and overflow
    bus_start();
    sendk("R6 addr", DEV_A, 1'b0);
    sendk("R6 cmd", 8'h00, 1'b0);
    sendk("R6 count", 8'd3, 1'b0);
    sendk("R6 d0", 8'hB0, 1'b0);
    sendk("R6 d1", 8'hB1, 1'b0);
    sendk("R6 d2", 8'hB2, 1'b0);
    sendk("R6 beyond count nack", 8'hB3, 1'b1);
    bus_stop();
    dn_chk("R6 reg0", 8'd0, 8'hB0);
    dn_chk("R6 reg1", 8'd1, 8'hB1);
    dn_chk("R6 reg2", 8'd2, 8'hB2);
    dn_chk("R6 reg3 untouched", 8'd3, RV);
    // R6 low bits ignored, early stop
    bus_start();
    sendk("R6 addr b", DEV_A, 1'b0);
    sendk("R6 cmd low bits", 8'h03, 1'b0);
    sendk("R6 count 5", 8'd5, 1'b0);
    sendk("R6 only byte", 8'hD1, 1'b0);
    bus_stop();
    dn_chk("R6 reg0 from offset 0", 8'd0, 8'hD1);
    dn_chk("R6 reg1 kept", 8'd1, 8'hB1);

    // R7 block read
    bus_start();
    sendk("R7 addr", DEV_A, 1'b0);
    sendk("R7 cmd", 8'h00, 1'b0);
    bus_rstart();
    sendk("R7 read addr", DEV_A | 8'h01, 1'b0);
    recv_expect("R7 count byte", 8'd4, 1'b1);
    recv_expect("R7 reg0", 8'hD1, 1'b1);
    recv_expect("R7 reg1", 8'hB1, 1'b1);
    recv_expect("R7 reg2", 8'hB2, 1'b1);
    recv_expect("R7 reg3", RV, 1'b0);
    bus_stop();
    chk("R7 line released", {31'd0, sda_low}, 32'd0);

    // R3 mismatch ignored
    bus_start();
    sendk("R3 wrong addr nack", DEV_B, 1'b1);
    sendk("R3 cmd ignored", 8'h86, 1'b1);
    sendk("R3 data ignored", 8'h99, 1'b1);
    bus_stop();
    dn_chk("R3 reg6 unchanged", 8'd6, 8'h42);

    // R2 strap selects second address
    strap = 1'b1;
    wr_reg("R2 addr B write", DEV_B, 7'd7, 8'h5C);
    dn_chk("R2 reg7 via B", 8'd7, 8'h5C);
    bus_start();
    sendk("R2 addr A refused", DEV_A, 1'b1);
    bus_stop();
    strap = 1'b0;

    // R9 start inside a byte aborts
    bus_start();
    sendk("R9 addr", DEV_A, 1'b0);
    sendk("R9 cmd", 8'h8A, 1'b0);
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
    bus_rstart();
    sendk("R9 new addr", DEV_A, 1'b0);
    sendk("R9 new cmd", 8'h8B, 1'b0);
    sendk("R9 new data", 8'h5A, 1'b0);
    bus_stop();
    dn_chk("R9 reg10 untouched", 8'd10, RV);
    dn_chk("R9 reg11 stored", 8'd11, 8'h5A);

    // R10 short clock spikes rejected
    bus_start();
    sendk("R10 addr", DEV_A, 1'b0);
    sendk("R10 cmd", 8'h8C, 1'b0);
    glitch_en = 1'b1;
    sendk("R10 data with spikes", 8'h6E, 1'b0);
    glitch_en = 1'b0;
    bus_stop();
    dn_chk("R10 reg12", 8'd12, 8'h6E);

    repeat (10) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule